// File: doc/BRIEF.md
# Pulse Add-Delete Symbol Clock Phase Adjuster

This block produces a local symbol clock for a bit-synchronization loop by counting pulses of a fast reference and dividing by twenty. A single fast clock running at twice the reference rate carries two interleaved pulse trains. Even cycles are main-train slots and odd cycles are auxiliary slots, so the two trains sit half a reference period apart. Merged pulses act as count enables for a divide-by-20 counter. The counter value sets the symbol clock, which is fed back to an external lead/lag phase detector.

Phase is steered by editing the pulse stream rather than by writing to the counter. A lead request swallows one main pulse, which retards the symbol clock by one twentieth of a symbol. A lag request injects one auxiliary pulse between two main pulses, which advances it by the same step. Only one request can be outstanding. It waits for the next slot of the right kind and is then spent. Phase detection and loop filtering sit outside this block.

Top module: `padj_phase_steer`

## Requirements
- R1: After reset is released, sym_clk_o is 1, tick_o is 0 and no request is pending. The first slot after release is a main slot. tick_o first rises 39 fast cycles after release, sampled after the 39th rising edge.
- R2: With no requests, tick_o is high for exactly one fast cycle in every 40.
- R3: sym_clk_o is high while the divider count is 0 to 9, and low while it is 10 to 19. With no requests this gives 20 high and 20 low fast cycles per symbol.
- R4: tick_o is high exactly in the first cycle of the symbol clock high phase, when the count has just returned to 0.
- R5: A single lead pulse deletes one main pulse. This makes the following three tick intervals total 122 fast cycles instead of 120.
- R6: A single lag pulse inserts one auxiliary pulse. This makes the following three tick intervals total 118 fast cycles instead of 120.
- R7: A request that arrives while another is pending is ignored. A lead held for two consecutive cycles therefore shifts the phase by one step only.
- R8: A lead and a lag in the same cycle cancel and leave the phase unchanged.
- R9: A pending request is applied at the first eligible slot after it is captured, and it is then cleared. The tick interval after the shift returns to 40 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the reference pulse rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lead_i | input | 1 | Request to retard the symbol clock by one step |
| lag_i | input | 1 | Request to advance the symbol clock by one step |
| sym_clk_o | output | 1 | Recovered symbol clock |
| tick_o | output | 1 | One-cycle pulse at each divider wrap |

## Verification
The bench builds the block with its default ratio of 20, which gives 40 fast cycles per symbol. At this size a sweep over every request arrival offset inside one symbol stays short. Each of the 40 offsets is applied to a lone lead, a lone lag, a simultaneous pair and a two-cycle lead. This covers requests landing on main slots, on auxiliary slots and right at the divider wrap. The expected interval sums come from simple arithmetic: 120 plus or minus 2.

// File: rtl/padj_pkg.sv
package padj_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_DEL  = 2'd1,
    REQ_INS  = 2'd2
  } req_e;
endpackage

// File: rtl/padj_slot_gen.sv
module padj_slot_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic main_slot_o,
  output logic aux_slot_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign main_slot_o = ~ph_q;
  assign aux_slot_o  = ph_q;

  AST_SLOT_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_slot_o |=> aux_slot_o); // R1
  AST_AUX_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_slot_o |=> main_slot_o); // R1
endmodule

// File: rtl/padj_req_ctrl.sv
module padj_req_ctrl
  import padj_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic lag_i,
  input  logic main_slot_i,
  input  logic aux_slot_i,
  output req_e pend_o
);
  req_e pend_q;
  logic applied;

  assign applied = ((pend_q == REQ_DEL) && main_slot_i) ||
                   ((pend_q == REQ_INS) && aux_slot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= REQ_NONE;
    end else if (pend_q == REQ_NONE) begin
      if (lead_i && !lag_i)      pend_q <= REQ_DEL;
      else if (lag_i && !lead_i) pend_q <= REQ_INS;
    end else if (applied) begin
      pend_q <= REQ_NONE;
    end
  end

  assign pend_o = pend_q;

  AST_BOTH_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i && lag_i && pend_q == REQ_NONE) |=> pend_q == REQ_NONE); // R8
  AST_BUSY_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != REQ_NONE && !applied) |=> pend_q == $past(pend_q)); // R7
  AST_SPENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    applied |=> pend_q == REQ_NONE); // R9
endmodule

// File: rtl/padj_divider.sv
module padj_divider #(
  parameter int unsigned DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sym_clk_o,
  output logic tick_o
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= en_i && (cnt_q == LAST);
      if (en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sym_clk_o = (cnt_q < CW'(HALF));
  assign tick_o    = tick_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R5
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != LAST) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
  AST_TICK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> cnt_q == '0); // R4
endmodule

// File: rtl/padj_phase_steer.sv
module padj_phase_steer
  import padj_pkg::*;
#(
  parameter int unsigned DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic lag_i,
  output logic sym_clk_o,
  output logic tick_o
);
  logic main_slot, aux_slot, cnt_en;
  req_e pend;

  padj_slot_gen u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .main_slot_o (main_slot),
    .aux_slot_o  (aux_slot)
  );

  padj_req_ctrl u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lead_i      (lead_i),
    .lag_i       (lag_i),
    .main_slot_i (main_slot),
    .aux_slot_i  (aux_slot),
    .pend_o      (pend)
  );

  // merged stream: main pulses unless swallowed, aux pulse only on insert
  assign cnt_en = (main_slot && (pend != REQ_DEL)) ||
                  (aux_slot && (pend == REQ_INS));

  padj_divider #(.DIV(DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en),
    .sym_clk_o (sym_clk_o),
    .tick_o    (tick_o)
  );

  AST_TICK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> sym_clk_o); // R4
  AST_DEL_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_slot && pend == REQ_DEL) |-> !cnt_en); // R5
  AST_INS_INJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_slot && pend == REQ_INS) |-> cnt_en); // R6
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: tb/sim_padj_phase_steer.sv
module sim_padj_phase_steer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lead_i = 1'b0;
  logic lag_i = 1'b0;
  logic sym_clk_o, tick_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  padj_phase_steer #(.DIV(20)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lead_i(lead_i), .lag_i(lag_i),
    .sym_clk_o(sym_clk_o), .tick_o(tick_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 lead, 1 lag, 2 both, 3 lead held two cycles
  task automatic run(input int kind, input int off);
    int nt = 0, t3 = 0, t4 = 0;
    string tag;
    do @(negedge clk); while (!tick_o);
    for (int c = 1; c <= 300; c++) begin
      lead_i = (kind != 1) && ((c == off + 1) || (kind == 3 && c == off + 2));
      lag_i  = (kind == 1 || kind == 2) && (c == off + 1);
      @(negedge clk);
      if (tick_o) begin
        nt++;
        if (nt == 3) t3 = c;
        if (nt == 4) t4 = c;
      end
      if (nt == 4) break;
    end
    lead_i = 1'b0;
    lag_i  = 1'b0;
    case (kind)
      0: begin tag = "R5 lead";         chk(tag, t3, 122); end
      1: begin tag = "R6 lag";          chk(tag, t3, 118); end
      2: begin tag = "R8 both";         chk(tag, t3, 120); end
      default: begin tag = "R7 held lead"; chk(tag, t3, 122); end
    endcase
    chk("R9 settle", t4 - t3, 40);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first, hi, n;
    repeat (3) @(negedge clk);
    chk("R1 sym_clk in reset", int'(sym_clk_o), 1);
    chk("R1 tick in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    first = 0;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      if (tick_o && first == 0) first = c;
    end
    chk("R1 first tick", first, 39);
    // steady state: period, duty, tick alignment
    do @(negedge clk); while (!tick_o);
    for (int p = 0; p < 3; p++) begin
      hi = 1; n = 1;
      chk("R4 tick with high phase", int'(sym_clk_o), 1);
      forever begin
        @(negedge clk);
        if (tick_o) break;
        n++;
        if (sym_clk_o) hi++;
      end
      chk("R2 period", n, 40);
      chk("R3 high cycles", hi, 20);
    end
    for (int k = 0; k < 4; k++)
      for (int off = 0; off < 40; off++)
        run(k, off);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule